// File: doc/BRIEF.md
# Static Memory Wait-State Controller

This block turns one-at-a-time read and write requests from an on-chip requester into the strobes needed by an external asynchronous static memory. Each access asserts chip select for a window whose length depends on two things. The first is a wait-state count supplied with the request. The second is an active-low stretch input driven by the memory device. The controller drives the address, an output-enable strobe for reads, a write-enable strobe and the write data with its drive enable. It captures the read data at the end of the window and reports completion with a one-cycle pulse.

The sequencer has four named states.
- `PH_IDLE` means ready for a request. It moves to `PH_WAIT` when a request is accepted (transition *accept*).
- `PH_WAIT` is the counted wait phase. It moves to `PH_TAIL` when the count has been reached and no stretch is held (transition *release*). Otherwise it stays in `PH_WAIT` (transition *hold*).
- `PH_TAIL` is a fixed three-cycle closing phase. It moves to `PH_DONE` after its last cycle (transition *close*).
- `PH_DONE` is the single completion cycle, with chip select inactive. It always returns to `PH_IDLE` (transition *retire*).

The stretch input goes through one sampling flop, and the state register adds a second stage. A stretch therefore counts only if it is present on the pin no later than the cycle before the programmed count expires.

Top module: `smc_wait_ctrl`

## Requirements
- R1: While `rst` is high and after it, with no request, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request (`req_valid` high) arriving while `req_ready` is 0 is ignored. It starts no access, and it changes neither the address nor the length of the access in progress.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `mem_cs_n` goes low in the very next cycle, and that cycle is wait cycle number 1.
- R4: Let N be the `req_waits` value, with N from 2 to 31. If `mem_wait_n` stays high, `mem_cs_n` is low for exactly N+3 consecutive cycles.
- R5: A `req_waits` value of 0 or 1 behaves exactly as 2.
- R6: Let N' be N after the floor of R5. Suppose `mem_wait_n` is low during wait cycles a through b, with 1 ≤ a ≤ N'−1, as sampled at the rising edge that ends each cycle. Then the window lasts max(N', b+2)+3 cycles.
- R7: If `mem_wait_n` first goes low in wait cycle N' or later, it has no effect, and the window lasts N'+3 cycles.
- R8: For a read, `mem_oe_n` is low in exactly the cycles where `mem_cs_n` is low. `mem_we_n` stays 1 and `mem_dout_en` stays 0 throughout.
- R9: For a write, `mem_dout_en` is 1 and `mem_dout` equals the request data in every cycle of the window. `mem_we_n` is low in every window cycle except the last, where it is 1. `mem_oe_n` stays 1.
- R10: `done` is 1 for exactly one cycle: the first cycle after the window ends. For a read, `rdata` then holds the `mem_din` value sampled at the edge that ends the last window cycle.
- R11: `mem_addr` holds the address latched at acceptance for the whole window. It does not follow later changes on `req_addr`.
- R12: `req_ready` is 0 from the cycle after acceptance through the `done` cycle. It is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_waits | input | WSW | Programmed wait-state count |
| req_ready | output | 1 | Controller idle, request may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Write data toward the memory |
| mem_dout_en | output | 1 | Drive enable for the data bus |
| mem_din | input | DW | Read data from the memory |
| mem_wait_n | input | 1 | Stretch request from the memory, active low |

## Verification
The bench builds the block with its defaults: 16-bit address and data and a 5-bit wait-state field. This makes every programmed count reachable, including the floor values 0 and 1, every count from 2 through 9, and the maximum of 31. For each count and for both directions, it sweeps the start and end cycles of the stretch. The sweep covers starting at cycle 1, starting at the last honoured cycle N'−1, starting one cycle too late, and ending before, at, and after the count. The expected window length comes from the max(N', b+2)+3 formula. Stray requests are sent during an access and in its completion cycle.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_TAIL = 2'd2,
        PH_DONE = 2'd3
    } smc_phase_e;

    // closing cycles after the stretch input is seen released
    localparam int unsigned TAIL_LEN = 3;
    // smallest count that still lets a stretch be recognised
    localparam int unsigned WS_MIN   = 2;

endpackage

// File: rtl/smc_wait_sampler.sv
module smc_wait_sampler (
    input  logic clk,
    input  logic rst,
    input  logic mem_wait_n,
    output logic wait_hold
);

    // first recognition stage; the phase register is the second
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_hold <= 1'b0;
        end else begin
            wait_hold <= ~mem_wait_n;
        end
    end

endmodule

// File: rtl/smc_phase_fsm.sv
module smc_phase_fsm
    import smc_pkg::*;
#(
    parameter int unsigned WSW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [WSW-1:0] waits,
    input  logic           wait_hold,
    output smc_phase_e     phase,
    output logic           last_cycle
);

    localparam int unsigned TW = (TAIL_LEN > 1) ? $clog2(TAIL_LEN) : 1;
    localparam logic [TW-1:0]  TAIL_LAST = TW'(TAIL_LEN - 1);
    localparam logic [WSW-1:0] WS_FLOOR  = WSW'(WS_MIN);
    localparam logic [WSW-1:0] CNT_MAX   = '1;

    smc_phase_e     phase_nx;
    logic [WSW-1:0] cnt;
    logic [WSW-1:0] lim;
    logic [TW-1:0]  tail;
    logic           count_met;

    assign count_met  = (cnt >= lim);
    assign last_cycle = (phase == PH_TAIL) && (tail == TAIL_LAST);

    // next-phase decision
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: phase_nx = start ? PH_WAIT : PH_IDLE;
            PH_WAIT: phase_nx = (count_met && !wait_hold) ? PH_TAIL : PH_WAIT;
            PH_TAIL: phase_nx = (tail == TAIL_LAST) ? PH_DONE : PH_TAIL;
            PH_DONE: phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // phase register and its counters
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            lim   <= WS_FLOOR;
            tail  <= '0;
        end else begin
            phase <= phase_nx;
            if (start) begin
                cnt <= WSW'(1);
                lim <= (waits < WS_FLOOR) ? WS_FLOOR : waits;
            end else if (phase == PH_WAIT && cnt != CNT_MAX) begin
                cnt <= cnt + WSW'(1);
            end
            if (phase == PH_TAIL) begin
                tail <= tail + TW'(1);
            end else begin
                tail <= '0;
            end
        end
    end

    // R4: the wait phase never ends before the programmed count
    a_r4_count_reached: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL && $past(phase) == PH_WAIT) |-> ($past(cnt) >= $past(lim)));

    // R6: the wait phase never ends while a stretch is recognised
    a_r6_release_seen: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL && $past(phase) == PH_WAIT) |-> !$past(wait_hold));

    // R5: the active limit is never below the floor
    a_r5_limit_floor: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> (lim >= WS_FLOOR));

    // R10: completion only follows the closing phase
    a_r10_done_after_tail: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |-> ($past(phase) == PH_TAIL));

endmodule

// File: rtl/smc_bus_drive.sv
module smc_bus_drive
    import smc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  smc_phase_e    phase,
    input  logic          last_cycle,
    input  logic [DW-1:0] mem_din,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en
);

    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          active;

    // request fields held from acceptance to completion; read capture
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (start) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (last_cycle && !wr_q) begin
                rdata <= mem_din;
            end
        end
    end

    // pin decode from the phase register
    always_comb begin
        active      = (phase == PH_WAIT) || (phase == PH_TAIL);
        mem_cs_n    = !active;
        mem_oe_n    = !(active && !wr_q);
        mem_we_n    = !(active && wr_q && !last_cycle);
        mem_dout_en = active && wr_q;
        mem_addr    = addr_q;
        mem_dout    = wdata_q;
        req_ready   = (phase == PH_IDLE);
        done        = (phase == PH_DONE);
    end

    // R9: write strobe only inside chip select
    a_r9_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    // R8: read and write strobes never overlap
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    // R10: completion pulse lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: address steady across the window
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R12: no acceptance while the window is open
    a_r12_busy_in_window: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);

endmodule

// File: rtl/smc_wait_ctrl.sv
module smc_wait_ctrl
    import smc_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned DW  = 16,
    parameter int unsigned WSW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [WSW-1:0] req_waits,
    output logic           req_ready,
    output logic           done,
    output logic [DW-1:0]  rdata,
    output logic           mem_cs_n,
    output logic           mem_oe_n,
    output logic           mem_we_n,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_dout,
    output logic           mem_dout_en,
    input  logic [DW-1:0]  mem_din,
    input  logic           mem_wait_n
);

    smc_phase_e phase;
    logic       last_cycle;
    logic       wait_hold;
    logic       start;

    assign start = req_valid && (phase == PH_IDLE);

    smc_wait_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .mem_wait_n (mem_wait_n),
        .wait_hold  (wait_hold)
    );

    smc_phase_fsm #(.WSW(WSW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .waits      (req_waits),
        .wait_hold  (wait_hold),
        .phase      (phase),
        .last_cycle (last_cycle)
    );

    smc_bus_drive #(.AW(AW), .DW(DW)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .last_cycle  (last_cycle),
        .mem_din     (mem_din),
        .req_ready   (req_ready),
        .done        (done),
        .rdata       (rdata),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en)
    );

    // R3: the window opens only from an accepted request
    a_r3_open_after_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n) |-> $past(req_valid && req_ready));

endmodule

// File: tb/smc_wait_ctrl_test.sv
module smc_wait_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [15:0] req_wdata;
    logic [4:0]  req_waits;
    logic        req_ready;
    logic        done;
    logic [15:0] rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n;
    logic [15:0] mem_addr, mem_dout;
    logic        mem_dout_en;
    logic [15:0] mem_din;
    logic        mem_wait_n;

    int checks = 0;
    int errors = 0;

    smc_wait_ctrl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_waits(req_waits),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_wait_n(mem_wait_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] din_pat(input logic [15:0] a, input int c);
        return a + 16'(c * 37) + 16'h0c00;
    endfunction

    // drive a request at a negedge in idle; all checks sampled at negedges
    task automatic run_access(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                              input int n, input int wa, input int wb, input bit stray);
        int    nn, e, l, c;
        string tag;
        nn = (n < 2) ? 2 : n;
        e  = nn;
        if (wa >= 1 && wa <= nn - 1) e = (wb + 2 > nn) ? wb + 2 : nn;
        l  = e + 3;
        if (n < 2)                        tag = "R5 window length";
        else if (wa >= 1 && wa <= nn - 1) tag = "R6 window length";
        else if (wa >= nn)                tag = "R7 window length";
        else                              tag = "R4 window length";

        chk(req_ready == 1'b1, "R12 ready in idle", int'(req_ready), 1);
        chk(mem_cs_n == 1'b1, "R3 cs high before accept", int'(mem_cs_n), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_waits = 5'(n);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~wd;
        chk(mem_cs_n == 1'b0, "R3 cs low after accept", int'(mem_cs_n), 0);
        c = 1;
        while (mem_cs_n == 1'b0 && c < 100) begin
            chk(req_ready == 1'b0, "R12 busy in window", int'(req_ready), 0);
            chk(mem_addr == a, "R11 address held", int'(mem_addr), int'(a));
            chk(done == 1'b0, "R10 no done in window", int'(done), 0);
            if (wr) begin
                chk(mem_dout_en == 1'b1 && mem_dout == wd, "R9 write data driven",
                    int'(mem_dout), int'(wd));
                chk(mem_we_n == (c == l), "R9 write strobe", int'(mem_we_n), int'(c == l));
                chk(mem_oe_n == 1'b1, "R9 oe idle on write", int'(mem_oe_n), 1);
            end else begin
                chk(mem_oe_n == 1'b0, "R8 oe low on read", int'(mem_oe_n), 0);
                chk(mem_we_n == 1'b1 && mem_dout_en == 1'b0, "R8 no write on read",
                    int'(mem_we_n), 1);
            end
            mem_wait_n = !(wa >= 1 && c >= wa && c <= wb);
            mem_din    = din_pat(a, c);
            req_valid  = stray && (c == 2);
            req_addr   = a ^ 16'h5a5a;
            @(negedge clk);
            c++;
        end
        chk(c - 1 == l, tag, c - 1, l);
        chk(done == 1'b1, "R10 done after window", int'(done), 1);
        if (!wr) chk(rdata == din_pat(a, l), "R10 read data", int'(rdata), int'(din_pat(a, l)));
        chk(req_ready == 1'b0, "R12 busy in done cycle", int'(req_ready), 0);
        mem_wait_n = 1'b1;
        req_valid  = stray;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
        chk(mem_cs_n == 1'b1, "R2 stray request ignored", int'(mem_cs_n), 1);
        chk(req_ready == 1'b1, "R12 ready after done", int'(req_ready), 1);
        if (stray) begin
            @(negedge clk);
            chk(mem_cs_n == 1'b1, "R2 no access from stray", int'(mem_cs_n), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_waits = '0; mem_din = '0; mem_wait_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset", int'(mem_cs_n), 1);
        chk(mem_dout_en == 1'b0 && done == 1'b0, "R1 bus released in reset", int'(mem_dout_en), 0);
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en, "R1 idle after reset",
            int'(mem_cs_n), 1);

        for (int n = 0; n < 10; n++) begin
            for (int w = 0; w < 2; w++) begin
                int nn;
                logic [15:0] a;
                nn = (n < 2) ? 2 : n;
                a  = 16'(n * 256 + w * 16 + 3);
                run_access(w[0], a, ~a, n, 0, 0, 1'b0);
                run_access(w[0], a + 1, a ^ 16'h3c3c, n, 1, 1, 1'b0);
                run_access(w[0], a + 2, a ^ 16'h0f0f, n, 1, nn + 3, 1'b0);
                if (nn - 1 >= 1) run_access(w[0], a + 3, a, n, nn - 1, nn + 2, 1'b0);
                run_access(w[0], a + 4, ~a, n, nn, nn + 5, 1'b1);
            end
        end
        run_access(1'b0, 16'hbeef, 16'h0, 31, 0, 0, 1'b0);
        run_access(1'b1, 16'h1234, 16'hcafe, 31, 30, 32, 1'b1);
        run_access(1'b0, 16'h4321, 16'h0, 31, 31, 33, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule